// File: doc/BRIEF.md
# Pulse Count Decimal Streamer

This block counts rising pulses on an asynchronous digital input and sends the running total out of a UART transmit line. It repeats this continuously and never pauses. The input is brought into the system clock domain through a two-flop synchronizer. A rising-edge detector then feeds a free-running binary counter. When the previous record has left the serial line, the sequencer captures the counter and converts the captured value to decimal. It then sends the digits most significant first, with leading zeros removed, and closes the record with one space byte.

There is no receive path and no command input. A host finds the number of pulses between two moments by subtracting two received totals. Counting goes on without interruption while a record is being sent. The whole block runs on one clock and uses one asynchronous active-low reset.

Top module: `pulse_ascii_streamer`

## Requirements
- R1: A pulse is counted exactly once when its high phase lasts at least two clock periods and the low phase that follows also lasts at least two clock periods.
- R2: A high level that begins and ends between two consecutive rising clock edges is not counted.
- R3: The counter is CNT_W bits wide and wraps from its all-ones value to zero.
- R4: Each record is the captured count in decimal, most significant digit first. Digit d is sent as byte code 48+d. Leading zeros are never sent, and a count of zero is sent as the single digit byte 48.
- R5: Each record ends with exactly one space byte (code 32). No other byte appears between the digits of one record and the next.
- R6: Every byte uses 8N1 framing: a low start bit, then eight data bits least significant first, then one high stop bit. Each bit lasts CLKS_PER_BIT clock cycles, and the line is high whenever no byte is in flight.
- R7: The start bit of a record's first byte begins no more than CNT_W+16 clock cycles after the stop bit of the previous record's space byte ends.
- R8: Pulses that arrive while a record is being sent are counted and appear in later records.
- R9: While rst_n is low, txd is high and the counter is cleared. The first record after reset is the single digit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the counter, converter and transmitter |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse input to be counted |
| txd | output | 1 | UART serial output, high when idle |

## Verification
The bench builds the block with CNT_W set to 10 and CLKS_PER_BIT set to 4. With these values the wrap from 1023 to 0 takes only about a thousand pulses. A four-digit record also takes only 200 clock cycles on the line, so many complete records pass in a short run. A serial receiver model in the bench decodes every byte. It checks the framing, leading-zero suppression and the gap between records for each record. The totals are compared against a running model after each group of pulses, after sub-cycle glitches, and after pulses spread across several records in flight.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;

  typedef enum logic [2:0] {
    SQ_SNAP,
    SQ_CONV,
    SQ_DIGIT,
    SQ_SPACE,
    SQ_DRAIN
  } seq_state_e;

  localparam logic [7:0] ASCII_ZERO  = 8'h30;
  localparam logic [7:0] ASCII_SPACE = 8'h20;

  // Decimal digits needed for the largest value of a given bit width
  // (floor(bits * log10(2)) + 1).
  function automatic int dec_digits(input int bits);
    return (bits * 30103) / 100000 + 1;
  endfunction

endpackage

// File: rtl/pcs_edge_counter.sv
`timescale 1ns/1ps
module pcs_edge_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  output logic [CNT_W-1:0] count
);

  // sync_q[0], sync_q[1]: synchronizer; sync_q[2]: previous synchronized level
  logic [2:0]       sync_q;
  logic             rise;
  logic [CNT_W-1:0] count_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pulse_in};
  end

  always_comb begin
    rise    = sync_q[1] & ~sync_q[2];
    count_d = count;
    if (rise) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  // R1 / R3: the count moves only by a single step, wrapping at all ones
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));

endmodule

// File: rtl/pcs_bcd_conv.sv
`timescale 1ns/1ps
module pcs_bcd_conv #(
  parameter int BIN_W  = 32,
  parameter int DIGITS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [BIN_W-1:0]      bin,
  output logic                  done,
  output logic [DIGITS*4-1:0]   bcd
);

  localparam int CNT_BITS = $clog2(BIN_W + 1);

  logic [BIN_W-1:0]    bin_q,  bin_d;
  logic [DIGITS*4-1:0] bcd_q,  bcd_d;
  logic [DIGITS*4-1:0] adj;
  logic [CNT_BITS-1:0] left_q, left_d;
  logic                done_q, done_d;

  // add-3 correction on every digit before each shift
  for (genvar g = 0; g < DIGITS; g++) begin : g_adj
    always_comb begin
      if (bcd_q[g*4 +: 4] >= 4'd5) adj[g*4 +: 4] = bcd_q[g*4 +: 4] + 4'd3;
      else                         adj[g*4 +: 4] = bcd_q[g*4 +: 4];
    end

    // R4: every finished digit lies in 0..9
    assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (bcd_q[g*4 +: 4] <= 4'd9));
  end

  always_comb begin
    bin_d  = bin_q;
    bcd_d  = bcd_q;
    left_d = left_q;
    done_d = 1'b0;
    if (start) begin
      bin_d  = bin;
      bcd_d  = '0;
      left_d = CNT_BITS'(BIN_W);
    end else if (left_q != '0) begin
      bcd_d  = {adj[DIGITS*4-2:0], bin_q[BIN_W-1]};
      bin_d  = {bin_q[BIN_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
      if (left_q == CNT_BITS'(1)) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      bcd_q  <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      bcd_q  <= bcd_d;
      left_q <= left_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign bcd  = bcd_q;

endmodule

// File: rtl/pcs_uart_tx.sv
`timescale 1ns/1ps
module pcs_uart_tx #(
  parameter int CLKS_PER_BIT = 868
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  output logic       idle,
  output logic       txd
);

  localparam int DIV_W = $clog2(CLKS_PER_BIT + 1);

  logic [9:0]       frame_q, frame_d;
  logic [3:0]       bits_q,  bits_d;
  logic [DIV_W-1:0] div_q,   div_d;
  logic             busy;
  logic             bit_end;

  always_comb begin
    busy    = (bits_q != 4'd0);
    bit_end = (div_q == DIV_W'(CLKS_PER_BIT - 1));
    frame_d = frame_q;
    bits_d  = bits_q;
    div_d   = div_q;
    if (load && !busy) begin
      frame_d = {1'b1, data, 1'b0};
      bits_d  = 4'd10;
      div_d   = '0;
    end else if (busy) begin
      if (bit_end) begin
        div_d   = '0;
        frame_d = {1'b1, frame_q[9:1]};
        bits_d  = bits_q - 1'b1;
      end else begin
        div_d   = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      bits_q  <= '0;
      div_q   <= '0;
    end else begin
      frame_q <= frame_d;
      bits_q  <= bits_d;
      div_q   <= div_d;
    end
  end

  assign idle = !busy;
  assign txd  = frame_q[0];

  // R6: a byte is only handed over while the line is free
  assert_load_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R6: the line rests high whenever no frame is in flight
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

endmodule

// File: rtl/pulse_ascii_streamer.sv
`timescale 1ns/1ps
module pulse_ascii_streamer
  import pcs_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int CLKS_PER_BIT = 868
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic txd
);

  localparam int DIGITS = dec_digits(CNT_W);
  localparam int IDX_W  = $clog2(DIGITS + 1);

  logic [CNT_W-1:0]    count;
  logic                conv_start;
  logic                conv_done;
  logic [DIGITS*4-1:0] bcd;
  logic                tx_load;
  logic [7:0]          tx_byte;
  logic                tx_idle;

  seq_state_e          state_q, state_d;
  logic [IDX_W-1:0]    idx_q,   idx_d;
  logic                seen_q,  seen_d;
  logic [3:0]          cur;

  pcs_edge_counter #(.CNT_W(CNT_W)) i_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_in (pulse_in),
    .count    (count)
  );

  // the converter's load on start is the record snapshot
  pcs_bcd_conv #(.BIN_W(CNT_W), .DIGITS(DIGITS)) i_conv (
    .clk   (clk),
    .rst_n (rst_n),
    .start (conv_start),
    .bin   (count),
    .done  (conv_done),
    .bcd   (bcd)
  );

  pcs_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tx_load),
    .data  (tx_byte),
    .idle  (tx_idle),
    .txd   (txd)
  );

  always_comb begin
    cur        = bcd[idx_q*4 +: 4];
    state_d    = state_q;
    idx_d      = idx_q;
    seen_d     = seen_q;
    conv_start = 1'b0;
    tx_load    = 1'b0;
    tx_byte    = ASCII_SPACE;
    case (state_q)
      SQ_SNAP: begin
        conv_start = 1'b1;
        state_d    = SQ_CONV;
      end
      SQ_CONV: begin
        if (conv_done) begin
          idx_d   = IDX_W'(DIGITS - 1);
          seen_d  = 1'b0;
          state_d = SQ_DIGIT;
        end
      end
      SQ_DIGIT: begin
        if (!seen_q && cur == 4'd0 && idx_q != '0) begin
          idx_d = idx_q - 1'b1;
        end else if (tx_idle) begin
          tx_load = 1'b1;
          tx_byte = ASCII_ZERO | {4'b0000, cur};
          seen_d  = 1'b1;
          if (idx_q == '0) state_d = SQ_SPACE;
          else             idx_d   = idx_q - 1'b1;
        end
      end
      SQ_SPACE: begin
        if (tx_idle) begin
          tx_load = 1'b1;
          tx_byte = ASCII_SPACE;
          state_d = SQ_DRAIN;
        end
      end
      SQ_DRAIN: begin
        if (tx_idle) state_d = SQ_SNAP;
      end
      default: state_d = SQ_SNAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_SNAP;
      idx_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      seen_q  <= seen_d;
    end
  end

  // R4 / R5: only digit codes or the separator reach the transmitter
  assert_byte_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (tx_byte == ASCII_SPACE ||
                 (tx_byte >= 8'd48 && tx_byte <= 8'd57)));

  // R4: the first digit of a record is a zero only when it is the last digit
  assert_no_lead_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && state_q == SQ_DIGIT && !seen_q) |->
      (tx_byte != ASCII_ZERO || idx_q == '0));

endmodule

// File: tb/test_pulse_ascii_streamer.sv
`timescale 1ns/1ps
module test_pulse_ascii_streamer;

  localparam int  CNT_W        = 10;
  localparam int  CPB          = 4;
  localparam time CLK_PERIOD   = 10;
  localparam int  NVEC         = 8;
  localparam int  VEC_ADD [NVEC] = '{1, 9, 89, 1, 922, 1, 1, 7};
  localparam int  VEC_EXP [NVEC] = '{1, 10, 99, 100, 1022, 1023, 0, 7};

  logic clk;
  logic rst_n;
  logic pulse_in;
  logic txd;

  int  compared   = 0;
  int  mismatched = 0;
  bit  finished   = 0;

  // receiver model state
  int  rec_count  = 0;
  int  last_val   = -1;
  int  last_len   = 0;
  int  acc        = 0;
  int  len        = 0;
  bit  zero_first = 0;
  bit  have_prev  = 0;
  time t_first;
  time t_prev_space;

  pulse_ascii_streamer #(.CNT_W(CNT_W), .CLKS_PER_BIT(CPB)) i_pulse_ascii_streamer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_in (pulse_in),
    .txd      (txd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ndig(input int v);
    int n = 1;
    while (v >= 10) begin v = v / 10; n++; end
    return n;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // serial receiver: samples each bit at its centre, half a clock away from edges
  always begin
    logic [7:0] b;
    time t0;
    @(negedge txd);
    t0 = $time;
    #(CLK_PERIOD/2 + CPB*CLK_PERIOD/2);
    if (txd !== 1'b0) check("R6 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin
      #(CPB*CLK_PERIOD);
      b[i] = txd;
    end
    #(CPB*CLK_PERIOD);
    check("R6 stop bit", txd, 1);
    if (b == 8'd32) begin
      check("R5 record has digits", len >= 1, 1);
      check("R4 no leading zero", zero_first && len > 1, 0);
      if (have_prev)
        check("R7 record gap", (t_first - (t_prev_space + 10*CPB*CLK_PERIOD)) <=
              (CNT_W + 16) * CLK_PERIOD, 1);
      have_prev    = 1;
      t_prev_space = t0;
      last_val     = acc;
      last_len     = len;
      acc          = 0;
      len          = 0;
      zero_first   = 0;
      rec_count++;
    end else if (b >= 8'd48 && b <= 8'd57) begin
      if (len == 0) begin
        t_first    = t0;
        zero_first = (b == 8'd48);
      end
      acc = acc * 10 + int'(b) - 48;
      len++;
    end else begin
      check("R5 byte code", b, 32);
    end
  end

  task automatic wait_records(input int n);
    int target = rec_count + n;
    while (rec_count < target) @(negedge clk);
  endtask

  task automatic give_pulses(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1;
      repeat (3) @(negedge clk);
      pulse_in = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual %0d expected %0d", rec_count, -1);
    finish_run();
  end

  initial begin
    pulse_in = 1'b0;
    rst_n    = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 txd high in reset", txd, 1);
    rst_n = 1'b1;

    // R9: first record after reset is "0 "
    wait_records(1);
    check("R9 first record value", last_val, 0);
    check("R9 first record length", last_len, 1);

    // R1 / R3 / R4 / R8 table walk
    for (int v = 0; v < NVEC; v++) begin
      give_pulses(VEC_ADD[v], 3);
      wait_records(2);
      check(VEC_EXP[v] == 0 ? "R3 wrap value" : "R1 count value", last_val, VEC_EXP[v]);
      check("R4 digit count", last_len, ndig(VEC_EXP[v]));
    end

    // R2: sub-cycle glitches between clock edges are ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1 pulse_in = 1'b1;
      #2 pulse_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    wait_records(2);
    check("R2 glitch ignored", last_val, 7);

    // R8: pulses spread across records in flight
    give_pulses(20, 47);
    wait_records(2);
    check("R8 counted during send", last_val, 27);
    check("R4 digit count", last_len, 2);

    // R1: minimum legal pulse (two cycles high, two low)
    for (int i = 0; i < 3; i++) begin
      pulse_in = 1'b1;
      repeat (2) @(negedge clk);
      pulse_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    wait_records(2);
    check("R1 minimum pulse", last_val, 30);

    finish_run();
  end

endmodule